// File: doc/BRIEF.md
# Configurable GPIO Bank Controller

A bank of up to sixteen general-purpose pins, programmed over a simple register bus with an address, a write enable, write data and combinational read data. Every pin has a four-bit mode field. One code makes the pin an input, one makes it an output driven from the data register, and each of the other fourteen codes routes a signal from a neighbouring peripheral onto the pin.

A bank of more than eight pins needs two control words, because each 32-bit word holds only eight mode fields. The data register then moves up one word. The data register can be written in any mode. Software can therefore preload an output level and then switch the pin to output, and the pin drives the preloaded level from its first cycle. Pad inputs pass through a two-flop synchroniser. The synchronised level is read back through the data register and is also passed to the alternate-function side.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all mode fields and all data bits are zero. Every mapped register reads 0 and padOe is all zero.
- R2: Register layout. Pin n<8 uses bits [4n+3:4n] of the control word at offset 0x0. When NUM_PINS>8, pin n≥8 uses bits [4(n-8)+3:4(n-8)] of the word at 0x4, and the data register sits at 0x8. Otherwise the data register sits at 0x4. Bit n of the data register belongs to pin n.
- R3: Mode 4'b0000 (input) holds padOe[n] at 0.
- R4: Mode 4'b0001 (output) sets padOe[n] to 1 and makes padOut[n] equal to data bit n.
- R5: Mode m in 2..15 drives padOut[n] from altOut[n*14+m-2] and padOe[n] from altOe[n*14+m-2].
- R6: A write to the data register updates the stored bit at the next rising edge whatever the pin's mode. A bit written while the pin is an input is driven as soon as the pin is switched to output.
- R7: A change on padIn[n] reaches altIn[n], and the data-register readback, after exactly two rising edges.
- R8: A data-register read returns the stored bit for a pin in output mode. For a pin in input or special mode it returns the synchronised pad level.
- R9: Writes to unmapped or unaligned offsets (0xC..0xF, or any address with bits [1:0] not zero) change no register, and reads of such offsets return 0.
- R10: Read data depends only on the current address and state, so it is valid in the same cycle the address is presented. Writes take effect at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the register |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data (combinational) |
| padIn | input | NUM_PINS | Asynchronous pad levels |
| padOut | output | NUM_PINS | Pad output values |
| padOe | output | NUM_PINS | Pad output enables |
| altOut | input | NUM_PINS*14 | Alternate-function output values, 14 per pin |
| altOe | input | NUM_PINS*14 | Alternate-function output enables, 14 per pin |
| altIn | output | NUM_PINS | Synchronised pad levels for the alternate functions |

## Verification
Some properties are checked on every cycle. No more than one write strobe is raised at a time, and none is raised for an unmapped address. An input-mode pin never drives. An output-mode pin drives its stored bit. A data write lands one cycle later in every mode. The synchroniser advances by one stage per edge. Other behaviours are shown only by the bench scenarios. These are the placement of each pin's field across the two control words, the alternate-function index selected by each mode code, preloading a level before a switch to output, the readback choice between stored and pad level, and the exact two-edge input latency measured at the ports.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W = 32;
  localparam int PINS_PER_WORD = 8;
  localparam int MAX_CTL = 2;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTL0 = 2'd1,
    RD_CTL1 = 2'd2,
    RD_DATA = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [MAX_CTL-1:0] wrCtl;
    logic               wrData;
    rdSel_e             rdSel;
  } strobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobe_t           strb
);
  localparam int NUM_CTL  = (NUM_PINS > PINS_PER_WORD) ? 2 : 1;
  localparam int DATA_OFF = NUM_CTL * 4;

  logic isCtl0, isCtl1, isData;

  always_comb begin
    isCtl0 = (busAddr == ADDR_W'(0));
    isCtl1 = (NUM_CTL == 2) && (busAddr == ADDR_W'(4));
    isData = (busAddr == ADDR_W'(DATA_OFF));

    strb.wrCtl  = {busWrEn & isCtl1, busWrEn & isCtl0};
    strb.wrData = busWrEn & isData;
    if (isCtl0)      strb.rdSel = RD_CTL0;
    else if (isCtl1) strb.rdSel = RD_CTL1;
    else if (isData) strb.rdSel = RD_DATA;
    else             strb.rdSel = RD_NONE;
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtl, strb.wrData}));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr[1:0] != 2'b00 || busAddr > ADDR_W'(DATA_OFF)))
      |-> (strb.wrCtl == '0 && !strb.wrData));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int MODE_W   = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  input  logic [BUS_W-1:0]               busWrData,
  output logic [BUS_W-1:0]               busRdData,
  input  logic [NUM_PINS-1:0]            padIn,
  output logic [NUM_PINS-1:0]            padOut,
  output logic [NUM_PINS-1:0]            padOe,
  input  logic [NUM_PINS*(2**MODE_W-2)-1:0] altOut,
  input  logic [NUM_PINS*(2**MODE_W-2)-1:0] altOe,
  output logic [NUM_PINS-1:0]            altIn
);
  localparam int NUM_ALT = 2**MODE_W - 2;
  localparam int SEL_W   = $clog2(NUM_ALT);

  logic [MODE_W-1:0]   modeReg [NUM_PINS];
  logic [NUM_PINS-1:0] dataReg;
  logic [NUM_PINS-1:0] syncQ1, syncQ2;
  logic [NUM_PINS-1:0] rdBits;
  logic [BUS_W-1:0]    ctlWord [MAX_CTL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1 <= '0;
      syncQ2 <= '0;
    end else begin
      syncQ1 <= padIn;
      syncQ2 <= syncQ1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataReg <= '0;
    else if (strb.wrData) dataReg <= busWrData[NUM_PINS-1:0];
  end

  assign altIn = syncQ2;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int WORD = n / PINS_PER_WORD;
    localparam int FLD  = n % PINS_PER_WORD;
    logic [NUM_ALT-1:0] pinAltOut, pinAltOe;
    logic [SEL_W-1:0]   altSel;
    logic               isIn, isOut;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 modeReg[n] <= '0;
      else if (strb.wrCtl[WORD]) modeReg[n] <= busWrData[MODE_W*FLD +: MODE_W];
    end

    always_comb begin
      pinAltOut = altOut[n*NUM_ALT +: NUM_ALT];
      pinAltOe  = altOe[n*NUM_ALT +: NUM_ALT];
      altSel    = SEL_W'(modeReg[n] - MODE_W'(2));
      isIn      = (modeReg[n] == MODE_W'(0));
      isOut     = (modeReg[n] == MODE_W'(1));
      if (isIn) begin
        padOut[n] = 1'b0;
        padOe[n]  = 1'b0;
      end else if (isOut) begin
        padOut[n] = dataReg[n];
        padOe[n]  = 1'b1;
      end else begin
        padOut[n] = pinAltOut[altSel];
        padOe[n]  = pinAltOe[altSel];
      end
      rdBits[n] = isOut ? dataReg[n] : syncQ2[n];
    end

    // R3
    input_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeReg[n] == MODE_W'(0)) |-> !padOe[n]);

    // R4
    output_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeReg[n] == MODE_W'(1)) |-> (padOe[n] && padOut[n] == dataReg[n]));

    // R6
    data_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrData |=> (dataReg[n] == $past(busWrData[n])));

    // R7
    sync_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
      altIn[n] == $past(syncQ1[n]));
  end

  always_comb begin
    for (int w = 0; w < MAX_CTL; w++) begin
      ctlWord[w] = '0;
      for (int f = 0; f < PINS_PER_WORD; f++) begin
        if (w * PINS_PER_WORD + f < NUM_PINS)
          ctlWord[w][MODE_W*f +: MODE_W] = modeReg[w * PINS_PER_WORD + f];
      end
    end
    case (strb.rdSel)
      RD_CTL0: busRdData = ctlWord[0];
      RD_CTL1: busRdData = ctlWord[1];
      RD_DATA: busRdData = BUS_W'(rdBits);
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int MODE_W   = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic                              busWrEn,
  input  logic [31:0]                       busWrData,
  output logic [31:0]                       busRdData,
  input  logic [NUM_PINS-1:0]               padIn,
  output logic [NUM_PINS-1:0]               padOut,
  output logic [NUM_PINS-1:0]               padOe,
  input  logic [NUM_PINS*(2**MODE_W-2)-1:0] altOut,
  input  logic [NUM_PINS*(2**MODE_W-2)-1:0] altOe,
  output logic [NUM_PINS-1:0]               altIn
);
  strobe_t strb;

  gpio_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb)
  );

  gpio_datapath #(.NUM_PINS(NUM_PINS), .MODE_W(MODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .busRdData(busRdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .altOut(altOut), .altOe(altOe), .altIn(altIn)
  );
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int NP = 16;
  localparam int NA = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe, altIn;
  logic [NP*NA-1:0] altOut = '0;
  logic [NP*NA-1:0] altOe = '0;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .altOut(altOut), .altOe(altOe),
    .altIn(altIn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdData;
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(4'h0, d); chk("R1 ctl0", d, 0);
    busRead(4'h4, d); chk("R1 ctl1", d, 0);
    busRead(4'h8, d); chk("R1 data", d, 0);
    chk("R1 padOe", 32'(padOe), 0);
  endtask

  task automatic testSyncInput();
    logic [31:0] d;
    @(negedge clk); padIn = 16'hA5C3;
    @(negedge clk);
    busRead(4'h8, d); chk("R7 one edge", d, 0);
    chk("R7 altIn one edge", 32'(altIn), 0);
    @(negedge clk);
    busRead(4'h8, d); chk("R7 R8 two edges", d, 32'hA5C3);
    chk("R7 altIn two edges", 32'(altIn), 32'hA5C3);
    chk("R3 input no drive", 32'(padOe), 0);
  endtask

  task automatic testPreloadOutput();
    logic [31:0] d;
    busWrite(4'h8, 32'h0000_0010);
    chk("R6 no drive before switch", 32'(padOe[4]), 0);
    busWrite(4'h0, 32'h0001_0000);
    chk("R4 R6 pin4 out", 32'({padOe[4], padOut[4]}), 32'b11);
    padIn[4] = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    busRead(4'h8, d); chk("R8 stored for out pin", 32'(d[4]), 1);
    busWrite(4'h8, 32'h0000_0000);
    chk("R6 write in output mode", 32'({padOe[4], padOut[4]}), 32'b10);
  endtask

  task automatic testUpperWord();
    logic [31:0] d;
    busWrite(4'h8, 32'h0000_0200);
    busWrite(4'h4, 32'h0000_0010);
    chk("R2 pin9 out", 32'({padOe[9], padOut[9]}), 32'b11);
    chk("R2 pin1 unaffected", 32'(padOe[1]), 0);
    busRead(4'h4, d); chk("R2 ctl1 readback", d, 32'h0000_0010);
    busRead(4'h0, d); chk("R2 ctl0 readback", d, 32'h0001_0000);
  endtask

  task automatic testAlt();
    logic [31:0] d;
    altOut[3*NA+3] = 1'b1; altOe[3*NA+3] = 1'b1;
    busWrite(4'h0, 32'h0001_5000);
    chk("R5 pin3 mode5 high", 32'({padOe[3], padOut[3]}), 32'b11);
    altOut[3*NA+3] = 1'b0; #0.5;
    chk("R5 pin3 mode5 low", 32'({padOe[3], padOut[3]}), 32'b10);
    altOut[3*NA+2] = 1'b1; #0.5;
    chk("R5 pin3 neighbour index", 32'(padOut[3]), 0);
    altOut[12*NA+13] = 1'b1; altOe[12*NA+13] = 1'b0;
    busWrite(4'h4, 32'h000F_0010);
    chk("R5 pin12 mode15", 32'({padOe[12], padOut[12]}), 32'b01);
    padIn[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    busRead(4'h8, d); chk("R8 special reads pad", 32'(d[3]), 1);
    chk("R7 altIn special", 32'(altIn[3]), 1);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busWrite(4'hC, 32'hFFFF_FFFF);
    busWrite(4'h1, 32'hFFFF_FFFF);
    busWrite(4'h9, 32'hFFFF_FFFF);
    busRead(4'h0, d); chk("R9 ctl0 kept", d, 32'h0001_5000);
    busRead(4'h4, d); chk("R9 ctl1 kept", d, 32'h000F_0010);
    chk("R9 data kept", 32'(padOut[9]), 1);
    busRead(4'hC, d); chk("R9 unmapped read", d, 0);
    busRead(4'h2, d); chk("R9 unaligned read", d, 0);
  endtask

  task automatic testSameCycleRead();
    logic [31:0] d;
    @(negedge clk);
    busAddr = 4'h4; #0.5; d = busRdData;
    chk("R10 read same cycle ctl1", d, 32'h000F_0010);
    busAddr = 4'h0; #0.5; d = busRdData;
    chk("R10 read same cycle ctl0", d, 32'h0001_5000);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSyncInput();
    testPreloadOutput();
    testUpperWord();
    testAlt();
    testUnmapped();
    testSameCycleRead();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule